// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller (Master/Slave)

This block moves one byte at a time over a four-wire synchronous serial link. A small register port gives access to a control register, a status register and a data register. As master, the block divides the system clock to make the serial clock, drives its own bit stream on the master-out pin and collects the bits on the master-in pin. As slave, it follows a serial clock and select that an outside master drives. The inputs pass through a two-stage synchronizer, so the outside clock must be well below the system clock.

The bit order, the clock idle level and the sampling edge can each be set. A completion flag rises when the eighth bit has been taken in. An interrupt request follows the flag when the local enable and an external global enable are both high. If the select input goes low while the block is master, some other master has taken the link. The block then falls back to slave, stops its transfer and raises the completion flag.

Top module: `spi_port`

## Requirements
- R1: Register addresses are 0 = control, 1 = status (flag in bit 7, other bits read 0), 2 = data. Control bits from bit 7 down to bit 0 are: interrupt enable, enable, LSB-first, master, clock polarity, clock phase, rate bit 1, rate bit 0. After reset, control reads 0x00, status reads 0x00, irq_o is 0 and miso_oe_o is 0.
- R2: While the enable bit is 0, a data write starts no transfer: sck_o holds its idle level and the flag stays 0.
- R3: When no master transfer is running, sck_o equals the clock-polarity bit (0 idles low, 1 idles high). The leading edge moves away from that level and the trailing edge returns to it.
- R4: In master mode with LSB-first at 0, a data write sends the byte on mosi_o most significant bit first. The byte taken in from miso_i can then be read at address 2.
- R5: With LSB-first at 1, bit 0 is sent first and the first received bit lands in bit 0.
- R6: With clock phase 0, bits are sampled on leading edges and changed on trailing edges. With clock phase 1, bits are changed on leading edges and sampled on trailing edges. Both directions behave this way in both modes.
- R7: In master mode, rate codes 0, 1, 2 and 3 give a serial clock of the system clock divided by 4, 16, 64 and 128. That is 2, 8, 32 and 64 system cycles between SCK edges, with 16 edges per byte.
- R8: The flag rises after the eighth sampling edge. It clears only when the status register is read while the flag is set and the data register is accessed afterwards. A data access with no status read before it leaves the flag set.
- R9: irq_o is 1 exactly when the flag, the interrupt-enable bit and global_ie_i are all 1.
- R10: If ss_n_i is low while the block is enabled and master, the master bit clears, any transfer stops and the flag sets. The block stays slave until the master bit is written to 1 again.
- R11: In slave mode, a low ss_n_i makes the block shift on sck_i: it takes a byte from mosi_i and sends the loaded data byte on miso_o. miso_oe_o is 1 only while the block is enabled, slave and selected.
- R12: In slave mode, ss_n_i going high in the middle of a byte drops the partial bits without setting the flag. The next full byte is received correctly.
- R13: The rate bits have no effect in slave mode. A slave transfer gives the same result with rate code 0 and with rate code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used to arm the flag clear) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| global_ie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Serial data out as master |
| miso_i | input | 1 | Serial data in as master |
| sck_i | input | 1 | Serial clock from an outside master |
| ss_n_i | input | 1 | Active-low select; mode-fault sense in master mode |
| mosi_i | input | 1 | Serial data in as slave |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
A wrong edge-role decode or a wrong bit counter shows up on the pins within one byte. The bits on mosi_o or miso_o come out shifted or mirrored, and the byte read back at address 2 is wrong as soon as the flag rises. A divider error changes the gap between SCK edges, and this shows at the second edge of a transfer. Errors in the flag, the clear handshake or the mode-fault path appear in the next status or control read and on irq_o, within a few cycles of the event that causes them.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int DATA_W = 8;
    localparam int HALF_W = 7;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_addr_e;

    // System cycles between successive SCK edges for each rate code
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] code);
        case (code)
            2'd0:    half_period = 7'd2;
            2'd1:    half_period = 7'd8;
            2'd2:    half_period = 7'd32;
            default: half_period = 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= rst_val_i;
            else if (s == 0) pipe[s] <= d_i;
            else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o,
    output logic       lead_o,
    output logic       last_o,
    output logic       phase_o
);
    logic [HALF_W-1:0] cnt_q;
    logic [3:0]        idx_q;
    logic              phase_q;

    assign tick_o  = run_i && (cnt_q == half_period(rate_i) - 7'd1);
    assign lead_o  = ~idx_q[0];
    assign last_o  = (idx_q == 4'd15);
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick_o) begin
            cnt_q   <= '0;
            idx_q   <= idx_q + 4'd1;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 7'd1;
        end
    end
endmodule

// File: rtl/spi_shift.sv
module spi_shift
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              clr_i,
    input  logic              lsb_first_i,
    input  logic              sample_i,
    input  logic              setup_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              idle_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [2:0]        cnt_q;

    assign dout_o = lsb_first_i ? tx_q[0] : tx_q[DATA_W-1];
    assign idle_o = (cnt_q == 3'd0);
    assign done_o = sample_i && (cnt_q == 3'd7) && !clr_i && !load_i;
    assign rx_o   = lsb_first_i ? {din_i, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], din_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            tx_q  <= load_data_i;
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else begin
            if (sample_i) begin
                rx_q  <= rx_o;
                cnt_q <= cnt_q + 3'd1;
            end
            // the first setup edge presents bit 0, which is already on the pin
            if (setup_i && cnt_q != 3'd0)
                tx_q <= lsb_first_i ? (tx_q >> 1) : (tx_q << 1);
        end
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              global_ie_i,
    output logic              irq_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o
);
    ctrl_t             ctrl_q;
    logic              flag_q, arm_q, busy_q, sck_prev_q;
    logic [DATA_W-1:0] rxbuf_q;

    logic [2:0] sync_q;
    logic       sck_s, ss_s, mosi_s;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .d_i({sck_i, ss_n_i, mosi_i}),
        .rst_val_i(3'b010),
        .q_o(sync_q)
    );
    assign {sck_s, ss_s, mosi_s} = sync_q;

    logic ctrl_wr, data_wr, data_acc, stat_rd;
    assign ctrl_wr  = wr_en_i && addr_i == REG_CTRL;
    assign data_wr  = wr_en_i && addr_i == REG_DATA;
    assign data_acc = (wr_en_i || rd_en_i) && addr_i == REG_DATA;
    assign stat_rd  = rd_en_i && addr_i == REG_STAT;

    logic fault, slave_act, start;
    assign fault     = ctrl_q.en && ctrl_q.master && !ss_s;
    assign slave_act = ctrl_q.en && !ctrl_q.master && !ss_s;

    logic m_tick, m_lead, m_last, m_phase;
    spi_rate_gen u_gen (
        .clk(clk), .rst(rst),
        .run_i(busy_q),
        .rate_i(ctrl_q.rate),
        .tick_o(m_tick), .lead_o(m_lead), .last_o(m_last), .phase_o(m_phase)
    );

    // edge strobes, shared by both modes
    logic s_edge, s_lead, edge_ev, lead_ev, sample, setup;
    assign s_edge  = slave_act && (sck_s != sck_prev_q);
    assign s_lead  = (sck_s != ctrl_q.cpol);
    assign edge_ev = ctrl_q.master ? m_tick : s_edge;
    assign lead_ev = ctrl_q.master ? m_lead : s_lead;
    assign sample  = edge_ev && (lead_ev != ctrl_q.cpha);
    assign setup   = edge_ev && (lead_ev == ctrl_q.cpha);

    logic sh_idle, sh_done, sh_load, sh_clr, dout;
    logic [DATA_W-1:0] sh_rx;
    assign start   = data_wr && ctrl_q.en && ctrl_q.master && !busy_q && !fault;
    assign sh_load = start || (data_wr && ctrl_q.en && !ctrl_q.master && (ss_s || sh_idle));
    assign sh_clr  = !ctrl_q.en || fault || (!ctrl_q.master && ss_s);

    spi_shift u_shift (
        .clk(clk), .rst(rst),
        .load_i(sh_load), .load_data_i(wdata_i),
        .clr_i(sh_clr),
        .lsb_first_i(ctrl_q.lsb_first),
        .sample_i(sample), .setup_i(setup),
        .din_i(ctrl_q.master ? miso_i : mosi_s),
        .dout_o(dout), .idle_o(sh_idle), .done_o(sh_done), .rx_o(sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            flag_q     <= 1'b0;
            arm_q      <= 1'b0;
            busy_q     <= 1'b0;
            rxbuf_q    <= '0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i);
            if (fault) ctrl_q.master <= 1'b0;

            if (fault || !ctrl_q.en) busy_q <= 1'b0;
            else if (start) busy_q <= 1'b1;
            else if (m_tick && m_last) busy_q <= 1'b0;

            if (sh_done) rxbuf_q <= sh_rx;

            if (sh_done || fault) begin
                flag_q <= 1'b1;
            end else if (arm_q && data_acc) begin
                flag_q <= 1'b0;
                arm_q  <= 1'b0;
            end else if (stat_rd && flag_q) begin
                arm_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr_i)
            REG_CTRL: rdata_o = ctrl_q;
            REG_STAT: rdata_o = {flag_q, 7'd0};
            REG_DATA: rdata_o = rxbuf_q;
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o     = flag_q && ctrl_q.ie && global_ie_i;
    assign sck_o     = ctrl_q.cpol ^ m_phase;
    assign mosi_o    = dout;
    assign miso_o    = dout;
    assign miso_oe_o = slave_act;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic master,
    input logic cpol,
    input logic busy,
    input logic tick,
    input logic ctrl_wr,
    input logic ss_s,
    input logic flag,
    input logic data_acc,
    input logic sck_o,
    input logic irq_o,
    input logic global_ie_i
);
    a_r2_no_run_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_o == cpol);

    a_r7_sck_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        busy && !tick && !ctrl_wr |=> $stable(sck_o));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag && !data_acc |=> flag);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag && global_ie_i);

    a_r10_mode_fault: assert property (@(posedge clk) disable iff (rst)
        en && master && !ss_s |=> !master && flag && !busy);
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst(rst),
    .en(ctrl_q.en), .master(ctrl_q.master), .cpol(ctrl_q.cpol),
    .busy(busy_q), .tick(m_tick), .ctrl_wr(ctrl_wr), .ss_s(ss_s),
    .flag(flag_q), .data_acc(data_acc), .sck_o(sck_o),
    .irq_o(irq_o), .global_ie_i(global_ie_i)
);

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
    logic       clk = 0, rst = 1;
    logic [1:0] addr_i = 0;
    logic       wr_en_i = 0, rd_en_i = 0;
    logic [7:0] wdata_i = 0, rdata_o;
    logic       global_ie_i = 0, irq_o;
    logic       sck_o, mosi_o, miso_i = 0;
    logic       sck_i = 0, ss_n_i = 1, mosi_i = 0;
    logic       miso_o, miso_oe_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_port u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); addr_i = a; wdata_i = d; wr_en_i = 1;
        @(negedge clk); wr_en_i = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr_i = a; rd_en_i = 1; #1 d = rdata_o;
        @(negedge clk); rd_en_i = 0;
    endtask

    function automatic logic bit_at(logic [7:0] b, int k, logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    task automatic clear_flag();
        logic [7:0] d;
        rd(1, d); rd(2, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(0, d); chk("R1 ctrl reset", d, 8'h00);
        rd(1, d); chk("R1 status reset", d, 8'h00);
        chk("R1 irq reset", irq_o, 0);
        chk("R1 miso_oe reset", miso_oe_o, 0);
    endtask

    task automatic t_disabled();
        logic [7:0] d; int tog = 0;
        wr(0, 8'h10);            // master, not enabled
        wr(2, 8'hA5);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); if (sck_o !== 1'b0) tog++;
        end
        chk("R2 sck held while disabled", tog, 0);
        rd(1, d); chk("R2 no flag while disabled", d, 8'h00);
    endtask

    task automatic t_master(logic cpol, logic cpha, logic lsb, logic [1:0] rate,
                            logic [7:0] tx, logic [7:0] rxb, string req);
        logic [7:0] d, got; logic prev; int edges = 0, s = 0, t0 = 0, gap = -1, c = 0;
        wr(0, {2'b01, lsb, 1'b1, cpol, cpha, rate});
        @(negedge clk); chk({"R3 idle level ", req}, sck_o, cpol);
        miso_i = bit_at(rxb, 0, lsb);
        got = 0;
        wr(2, tx);
        prev = sck_o;
        while (edges < 16 && c < 5000) begin
            @(negedge clk); c++;
            if (sck_o !== prev) begin
                logic lead; lead = (edges % 2 == 0);
                if (edges == 0) t0 = c;
                if (edges == 1) gap = c - t0;
                if (lead != cpha) begin
                    if (lsb) got[s] = mosi_o; else got[7-s] = mosi_o;
                    s++;
                end else if (s > 0 && s < 8) begin
                    miso_i = bit_at(rxb, s, lsb);
                end
                edges++;
            end
            prev = sck_o;
        end
        repeat (4) @(negedge clk);
        chk({"R7 edge gap ", req}, gap, (rate == 0) ? 2 : (rate == 1) ? 8 : (rate == 2) ? 32 : 64);
        chk({"R4/R5/R6 mosi byte ", req}, got, tx);
        chk({"R3 back to idle ", req}, sck_o, cpol);
        rd(2, d); chk({"R4/R5/R6 rx byte ", req}, d, rxb);
        rd(1, d); chk({"R8 flag survives data read ", req}, d, 8'h80);
        rd(2, d); rd(1, d); chk({"R8 flag cleared ", req}, d, 8'h00);
    endtask

    task automatic sedge();
        sck_i = ~sck_i; repeat (8) @(negedge clk);
    endtask

    task automatic t_slave(logic cpol, logic cpha, logic lsb, logic [1:0] rate,
                           logic [7:0] tx, logic [7:0] mb, string req);
        logic [7:0] d, got;
        got = 0;
        sck_i = cpol;
        wr(0, {2'b01, lsb, 1'b0, cpol, cpha, rate});
        wr(2, tx);
        ss_n_i = 0; repeat (8) @(negedge clk);
        chk({"R11 miso_oe selected ", req}, miso_oe_o, 1);
        for (int k = 0; k < 8; k++) begin
            if (!cpha) begin
                mosi_i = bit_at(mb, k, lsb); repeat (8) @(negedge clk);
                if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
                sedge(); sedge();
            end else begin
                sedge(); mosi_i = bit_at(mb, k, lsb); repeat (8) @(negedge clk);
                if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
                sedge();
            end
        end
        repeat (4) @(negedge clk);
        chk({"R11 miso byte ", req}, got, tx);
        rd(1, d); chk({"R8 slave flag ", req}, d, 8'h80);
        rd(2, d); chk({"R11/R13 slave rx ", req}, d, mb);
        ss_n_i = 1; repeat (4) @(negedge clk);
        chk({"R11 miso_oe released ", req}, miso_oe_o, 0);
        rd(1, d); chk({"R8 slave flag cleared ", req}, d, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        sck_i = 0;
        wr(0, 8'h40); wr(2, 8'h00);
        ss_n_i = 0; repeat (8) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            mosi_i = 1; repeat (8) @(negedge clk); sedge(); sedge();
        end
        ss_n_i = 1; repeat (8) @(negedge clk);
        rd(1, d); chk("R12 no flag after abort", d, 8'h00);
        t_slave(0, 0, 0, 2'd0, 8'h5A, 8'h81, "after abort R12");
    endtask

    task automatic t_fault();
        logic [7:0] d;
        wr(0, 8'h50);            // enabled master
        ss_n_i = 0; repeat (6) @(negedge clk);
        ss_n_i = 1; repeat (4) @(negedge clk);
        rd(0, d); chk("R10 master cleared", d, 8'h40);
        rd(1, d); chk("R10 flag set by fault", d, 8'h80);
    endtask

    task automatic t_irq();
        wr(0, 8'hC0);            // interrupt enable, enabled, slave
        global_ie_i = 0; @(negedge clk);
        chk("R9 irq needs global enable", irq_o, 0);
        global_ie_i = 1; @(negedge clk);
        chk("R9 irq asserted", irq_o, 1);
        wr(0, 8'h40); @(negedge clk);
        chk("R9 irq needs local enable", irq_o, 0);
        wr(0, 8'hC0); clear_flag(); @(negedge clk);
        chk("R9 irq drops with flag", irq_o, 0);
        global_ie_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk); rst = 0;
        t_reset();
        t_disabled();
        t_master(0, 0, 0, 2'd0, 8'hA5, 8'h3C, "mode0 msb R4");
        t_master(0, 0, 1, 2'd1, 8'h96, 8'h1E, "mode0 lsb R5");
        t_master(0, 1, 0, 2'd0, 8'hC3, 8'h5B, "mode1 R6");
        t_master(1, 0, 1, 2'd2, 8'h2D, 8'hE1, "mode2 R3");
        t_master(1, 1, 0, 2'd3, 8'h71, 8'h8E, "mode3 R7");
        t_fault();
        t_irq();
        t_slave(0, 0, 0, 2'd3, 8'hB4, 8'h69, "mode0 rate3 R13");
        t_slave(0, 0, 0, 2'd0, 8'hB4, 8'h69, "mode0 rate0 R13");
        t_slave(1, 1, 1, 2'd1, 8'h4E, 8'hD2, "mode3 lsb R6");
        t_abort();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule